// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is one logic cell of a programmable-logic fabric. It takes an already-formed sum term and returns it in one of three forms: passed straight through, held in a level-sensitive latch, or captured in an edge-triggered register. A feedback copy of the result is always produced. A separate routed output carries the same value only when the cell is enabled to drive a pin.

The storage element is clocked either from one of several shared block clocks (synchronous mode) or from the cell's own product-term clock, on a chosen edge (asynchronous mode). Mode also decides where initialization comes from. In synchronous mode two shared block terms set and clear the cell, and a swap bit exchanges their roles. In asynchronous mode a single private term either sets or clears the cell, as configured. Set and clear take effect on the output without waiting for a clock edge, and clear wins over set. An optional XOR of the input with the stored value turns the register into a toggle element.

Clock inputs are sampled by the system clock `clk`. A rise of the selected clock level is detected there, and the register loads on the next `clk` edge. Latch transparency and initialization act on the outputs combinationally.

Top module: `mc_cell`

## Requirements
- R1: While reset is applied and after its release, with no edge or initialization since, the stored value is 0, so in registered type both `mc_fb` and `mc_out` read 0.
- R2: `cfg_kind` encodes the type: 0 combinational, 1 latched, 2 registered, 3 also combinational. In combinational type `mc_fb` equals `sum_in` in the same cycle, and the initialization terms have no effect on it.
- R3: In registered type the stored value takes `sum_in` at a rise of the selected clock level and holds at all other times. The new value appears in the `clk` cycle after the one in which the rise is first seen.
- R4: In latched type the output follows `sum_in` while the selected clock level is high. While the level is low the output holds the value sampled at the last `clk` edge with the level high.
- R5: In synchronous mode (`cfg_async`=0), `cfg_clk_sel` picks `blk_clk[cfg_clk_sel]` as the clock. The other block clocks and `pt_clk` have no effect.
- R6: In asynchronous mode (`cfg_async`=1), `pt_clk` is the clock. With `cfg_pt_fall`=0 its rising edge is used; with `cfg_pt_fall`=1 its falling edge is used and the latch is transparent while `pt_clk` is low. Block clocks have no effect in this mode.
- R7: In synchronous mode with `cfg_swap`=0, `blk_init[0]` sets the value to 1 and `blk_init[1]` clears it to 0. `cfg_swap`=1 exchanges the two roles, and `pt_init` has no effect.
- R8: In asynchronous mode `pt_init` clears the value when `cfg_pt_to_rst`=1 and sets it when `cfg_pt_to_rst`=0. `blk_init` has no effect in this mode.
- R9: Set and clear act on the latched and registered outputs in the same cycle, with no clock edge, and override a concurrent clock edge. When both are active, clear wins.
- R10: With `cfg_tff`=1 in registered type, a clock rise stores `sum_in` XOR the current value: `sum_in`=1 toggles the value and `sum_in`=0 keeps it.
- R11: `mc_out` equals the cell value when `cfg_route`=1 and reads 0 when `cfg_route`=0. `mc_fb` carries the value in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all clock and data inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sum_in | input | 1 | Sum term to be passed, latched or registered |
| blk_clk | input | N_BLK_CLK (4) | Shared block clock levels |
| pt_clk | input | 1 | Individual product-term clock level |
| blk_init | input | 2 | Shared block initialization terms |
| pt_init | input | 1 | Individual initialization term |
| cfg_kind | input | 2 | Type: 0 comb, 1 latch, 2 register, 3 comb |
| cfg_async | input | 1 | 0 synchronous mode, 1 asynchronous mode |
| cfg_clk_sel | input | 2 | Block clock index in synchronous mode |
| cfg_pt_fall | input | 1 | Use falling edge (low level) of `pt_clk` |
| cfg_swap | input | 1 | Exchange set and clear roles of `blk_init` |
| cfg_pt_to_rst | input | 1 | 1: `pt_init` clears, 0: `pt_init` sets |
| cfg_tff | input | 1 | XOR input with stored value (toggle behaviour) |
| cfg_route | input | 1 | Enable the routed output |
| mc_out | output | 1 | Routed cell value |
| mc_fb | output | 1 | Feedback cell value, always valid |

## Verification
The register is driven with pulses on the selected block clock and also on every unselected block clock and on the product-term clock. This separates a correct clock choice from one that listens to the wrong source, or to any source. The latch is driven with data changes both while its clock is high and after it falls, which tells transparency apart from edge capture and from a missing hold. Initialization is applied without a clock, during a clock edge, both terms at once, and with the swap bit and mode flipped. This exposes wrong polarity, a lost priority or a term that should be ignored. Toggle runs with a data value of one and of zero, which separates XOR feedback from plain capture.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MC_COMB     = 2'd0,
    MC_LATCH    = 2'd1,
    MC_REG      = 2'd2,
    MC_COMB_ALT = 2'd3
  } mc_kind_e;

  typedef struct packed {
    logic to_lo;
    logic to_hi;
  } mc_force_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/mc_clk_pick.sv
module mc_clk_pick #(
  parameter int N_CLK = 4,
  localparam int SEL_W = (N_CLK > 1) ? $clog2(N_CLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             async_mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             pt_fall,
  input  logic [N_CLK-1:0] blk_clk,
  input  logic             pt_clk,
  output logic             lvl,
  output logic             rise
);

  logic lvl_blk;
  logic lvl_pt;
  logic prev_q;
  logic prev_d;

  // R5: pick one shared block clock by index
  always_comb begin
    lvl_blk = 1'b0;
    for (int i = 0; i < N_CLK; i++) begin
      if (sel == SEL_W'(i)) begin
        lvl_blk = blk_clk[i];
      end
    end
  end

  // R6: falling-edge use inverts the individual clock
  assign lvl_pt = pt_clk ^ pt_fall;
  assign lvl    = async_mode ? lvl_pt : lvl_blk;

  always_comb begin
    prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign rise = lvl & ~prev_q;

  // R3: one detected rise never repeats in the next cycle
  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/mc_init_pick.sv
module mc_init_pick
  import mc_pkg::*;
(
  input  logic       async_mode,
  input  logic       swap,
  input  logic       pt_to_rst,
  input  logic [1:0] blk_init,
  input  logic       pt_init,
  output mc_force_t  frc
);

  logic set_sync;
  logic clr_sync;
  logic set_async;
  logic clr_async;
  logic set_any;
  logic clr_any;

  // R7: shared terms, roles exchanged by the swap bit
  always_comb begin
    if (swap) begin
      set_sync = blk_init[1];
      clr_sync = blk_init[0];
    end else begin
      set_sync = blk_init[0];
      clr_sync = blk_init[1];
    end
  end

  // R8: one private term, steered to clear or set
  always_comb begin
    clr_async = pt_init & pt_to_rst;
    set_async = pt_init & ~pt_to_rst;
  end

  always_comb begin
    if (async_mode) begin
      set_any = set_async;
      clr_any = clr_async;
    end else begin
      set_any = set_sync;
      clr_any = clr_sync;
    end
  end

  // R9: clear has priority over set
  always_comb begin
    frc.to_lo = clr_any;
    frc.to_hi = set_any & ~clr_any;
  end

endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mc_kind_e  kind,
  input  logic      tff,
  input  logic      sum,
  input  logic      lvl,
  input  logic      rise,
  input  mc_force_t frc,
  output logic      val
);

  logic q_r;
  logic q_d;
  logic q_en;
  logic forced;
  logic reg_load;
  logic lat_load;
  logic d_reg;

  assign forced   = frc.to_lo | frc.to_hi;
  assign reg_load = (kind == MC_REG) & rise;
  assign lat_load = (kind == MC_LATCH) & lvl;
  // R10: toggle behaviour through XOR with stored value
  assign d_reg    = sum ^ (tff & q_r);

  always_comb begin
    q_en = forced | reg_load | lat_load;
    q_d  = q_r;
    if (frc.to_lo) begin
      q_d = 1'b0;
    end else if (frc.to_hi) begin
      q_d = 1'b1;
    end else if (reg_load) begin
      q_d = d_reg;
    end else if (lat_load) begin
      q_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (q_en) begin
      q_r <= q_d;
    end
  end

  // R2, R4, R9: output view per type; forcing bypasses the clock
  always_comb begin
    case (kind)
      MC_REG: begin
        if (frc.to_lo)      val = 1'b0;
        else if (frc.to_hi) val = 1'b1;
        else                val = q_r;
      end
      MC_LATCH: begin
        if (frc.to_lo)      val = 1'b0;
        else if (frc.to_hi) val = 1'b1;
        else if (lvl)       val = sum;
        else                val = q_r;
      end
      default: val = sum;
    endcase
  end

  // R3: a rise loads the data term on the following edge
  a_r3_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == MC_REG && rise && !forced) |=> (q_r == $past(sum ^ (tff & q_r))));

  // R3: without rise or forcing the register holds
  a_r3_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == MC_REG && !rise && !forced) |=> $stable(q_r));

  // R4: while transparent, the stored copy tracks the data term
  a_r4_latch_track: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == MC_LATCH && lvl && !forced) |=> (q_r == $past(sum)));

endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter int N_BLK_CLK  = 4,
  parameter int RST_STAGES = 2,
  localparam int CSW = (N_BLK_CLK > 1) ? $clog2(N_BLK_CLK) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sum_in,
  input  logic [N_BLK_CLK-1:0] blk_clk,
  input  logic                 pt_clk,
  input  logic [1:0]           blk_init,
  input  logic                 pt_init,
  input  logic [1:0]           cfg_kind,
  input  logic                 cfg_async,
  input  logic [CSW-1:0]       cfg_clk_sel,
  input  logic                 cfg_pt_fall,
  input  logic                 cfg_swap,
  input  logic                 cfg_pt_to_rst,
  input  logic                 cfg_tff,
  input  logic                 cfg_route,
  output logic                 mc_out,
  output logic                 mc_fb
);

  logic      rst_n_s;
  logic      clk_lvl;
  logic      clk_rise;
  mc_force_t frc;
  logic      cell_val;
  mc_kind_e  kind;

  assign kind = mc_kind_e'(cfg_kind);

  mc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  mc_clk_pick #(.N_CLK(N_BLK_CLK)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .async_mode (cfg_async),
    .sel        (cfg_clk_sel),
    .pt_fall    (cfg_pt_fall),
    .blk_clk    (blk_clk),
    .pt_clk     (pt_clk),
    .lvl        (clk_lvl),
    .rise       (clk_rise)
  );

  mc_init_pick u_init (
    .async_mode (cfg_async),
    .swap       (cfg_swap),
    .pt_to_rst  (cfg_pt_to_rst),
    .blk_init   (blk_init),
    .pt_init    (pt_init),
    .frc        (frc)
  );

  mc_store u_store (
    .clk   (clk),
    .rst_n (rst_n_s),
    .kind  (kind),
    .tff   (cfg_tff),
    .sum   (sum_in),
    .lvl   (clk_lvl),
    .rise  (clk_rise),
    .frc   (frc),
    .val   (cell_val)
  );

  // R11: routed copy gated, feedback copy always present
  assign mc_fb  = cell_val;
  assign mc_out = cfg_route & cell_val;

  // R9: a shared clear term pins a register cell low at the ports
  a_r9_clear_at_port: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_kind == 2'd2 && !cfg_async && !cfg_swap && blk_init[1]) |-> !mc_fb);

  // R2: combinational types pass the sum term through to feedback
  a_r2_comb_pass: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_kind == 2'd0 || cfg_kind == 2'd3) |-> (mc_fb == sum_in));

endmodule

// File: tb/mc_cell_tb.sv
module mc_cell_tb;

  logic       clk;
  logic       rst_n;
  logic       sum_in;
  logic [3:0] blk_clk;
  logic       pt_clk;
  logic [1:0] blk_init;
  logic       pt_init;
  logic [1:0] cfg_kind;
  logic       cfg_async;
  logic [1:0] cfg_clk_sel;
  logic       cfg_pt_fall;
  logic       cfg_swap;
  logic       cfg_pt_to_rst;
  logic       cfg_tff;
  logic       cfg_route;
  logic       mc_out;
  logic       mc_fb;

  int n_chk = 0;
  int n_err = 0;

  mc_cell u_dut (
    .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .blk_clk(blk_clk),
    .pt_clk(pt_clk), .blk_init(blk_init), .pt_init(pt_init),
    .cfg_kind(cfg_kind), .cfg_async(cfg_async), .cfg_clk_sel(cfg_clk_sel),
    .cfg_pt_fall(cfg_pt_fall), .cfg_swap(cfg_swap),
    .cfg_pt_to_rst(cfg_pt_to_rst), .cfg_tff(cfg_tff), .cfg_route(cfg_route),
    .mc_out(mc_out), .mc_fb(mc_fb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_blk(input int idx);
    blk_clk[idx] = 1'b1;
    tick(1);
    blk_clk[idx] = 1'b0;
    tick(1);
  endtask

  task automatic pulse_pt();
    pt_clk = ~pt_clk;
    tick(1);
    pt_clk = ~pt_clk;
    tick(1);
  endtask

  // sync mode, no swap: blk_init[0] sets, blk_init[1] clears
  task automatic set_val(input logic v);
    blk_init = v ? 2'b01 : 2'b10;
    tick(1);
    blk_init = 2'b00;
    tick(1);
  endtask

  task automatic t_reset();
    tick(1);
    chk("R1 during reset", mc_fb, 1'b0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 fb after release", mc_fb, 1'b0);
    chk("R1 out after release", mc_out, 1'b0);
  endtask

  task automatic t_comb();
    cfg_kind = 2'd0;
    sum_in = 1'b1;
    #1 chk("R2 comb high", mc_fb, 1'b1);
    tick(1);
    sum_in = 1'b0;
    #1 chk("R2 comb low", mc_fb, 1'b0);
    tick(1);
    blk_init = 2'b01;
    #1 chk("R2 comb ignores set", mc_fb, 1'b0);
    tick(1);
    blk_init = 2'b00;
    cfg_kind = 2'd3;
    sum_in = 1'b1;
    #1 chk("R2 code 3 is comb", mc_fb, 1'b1);
    tick(1);
  endtask

  task automatic t_reg_sync();
    cfg_kind = 2'd2;
    cfg_clk_sel = 2'd2;
    tick(1);
    set_val(1'b0);
    sum_in = 1'b1;
    pulse_blk(2);
    chk("R3 capture on selected rise", mc_fb, 1'b1);
    sum_in = 1'b0;
    tick(3);
    chk("R3 hold without edge", mc_fb, 1'b1);
    pulse_blk(0);
    chk("R5 block clock 0 ignored", mc_fb, 1'b1);
    pulse_blk(3);
    chk("R5 block clock 3 ignored", mc_fb, 1'b1);
    pulse_pt();
    chk("R5 pt clock ignored in sync", mc_fb, 1'b1);
    pulse_blk(2);
    chk("R3 capture zero", mc_fb, 1'b0);
    cfg_clk_sel = 2'd1;
    sum_in = 1'b1;
    tick(1);
    pulse_blk(2);
    chk("R5 old clock ignored after reselect", mc_fb, 1'b0);
    pulse_blk(1);
    chk("R5 new clock used", mc_fb, 1'b1);
  endtask

  task automatic t_latch();
    cfg_kind = 2'd1;
    cfg_clk_sel = 2'd0;
    tick(1);
    set_val(1'b0);
    sum_in = 1'b1;
    tick(1);
    chk("R4 closed latch holds", mc_fb, 1'b0);
    blk_clk[0] = 1'b1;
    #1 chk("R4 transparent high", mc_fb, 1'b1);
    tick(1);
    sum_in = 1'b0;
    #1 chk("R4 transparent follows", mc_fb, 1'b0);
    tick(1);
    sum_in = 1'b1;
    tick(1);
    blk_clk[0] = 1'b0;
    #1 chk("R4 closes on last value", mc_fb, 1'b1);
    tick(1);
    sum_in = 1'b0;
    #1 chk("R4 hold while low", mc_fb, 1'b1);
    tick(2);
    chk("R4 hold later", mc_fb, 1'b1);
  endtask

  task automatic t_async_clk();
    cfg_kind = 2'd2;
    cfg_async = 1'b1;
    cfg_pt_fall = 1'b0;
    cfg_pt_to_rst = 1'b1;
    pt_clk = 1'b0;
    tick(1);
    pt_init = 1'b1;
    tick(1);
    pt_init = 1'b0;
    tick(1);
    sum_in = 1'b1;
    pulse_blk(int'(cfg_clk_sel));
    chk("R6 block clock ignored in async", mc_fb, 1'b0);
    pulse_pt();
    chk("R6 pt rising capture", mc_fb, 1'b1);
    pt_clk = 1'b1;
    cfg_pt_fall = 1'b1;
    tick(2);
    chk("R6 no capture on mode switch", mc_fb, 1'b1);
    sum_in = 1'b0;
    pt_clk = 1'b0;
    tick(1);
    chk("R6 pt falling capture", mc_fb, 1'b0);
    sum_in = 1'b1;
    pt_clk = 1'b1;
    tick(2);
    chk("R6 pt rising ignored in fall mode", mc_fb, 1'b0);
    pt_clk = 1'b0;
    tick(1);
    chk("R6 second falling capture", mc_fb, 1'b1);
    cfg_pt_fall = 1'b0;
    tick(1);
    cfg_async = 1'b0;
    tick(1);
  endtask

  task automatic t_init_sync();
    cfg_kind = 2'd2;
    cfg_swap = 1'b0;
    blk_init = 2'b10;
    #1 chk("R7 blk_init[1] clears", mc_fb, 1'b0);
    tick(1);
    blk_init = 2'b01;
    #1 chk("R9 set acts without clock", mc_fb, 1'b1);
    tick(1);
    blk_init = 2'b00;
    tick(2);
    chk("R7 set value retained", mc_fb, 1'b1);
    cfg_swap = 1'b1;
    blk_init = 2'b01;
    #1 chk("R7 swapped blk_init[0] clears", mc_fb, 1'b0);
    tick(1);
    blk_init = 2'b10;
    #1 chk("R7 swapped blk_init[1] sets", mc_fb, 1'b1);
    tick(1);
    blk_init = 2'b11;
    #1 chk("R9 clear wins over set", mc_fb, 1'b0);
    tick(1);
    blk_init = 2'b10;
    tick(1);
    blk_init = 2'b00;
    tick(1);
    pt_init = 1'b1;
    #1 chk("R7 pt_init ignored in sync", mc_fb, 1'b1);
    tick(1);
    pt_init = 1'b0;
    tick(1);
    chk("R7 value after pt_init", mc_fb, 1'b1);
    cfg_swap = 1'b0;
    sum_in = 1'b1;
    blk_init = 2'b10;
    blk_clk[cfg_clk_sel] = 1'b1;
    tick(1);
    blk_clk[cfg_clk_sel] = 1'b0;
    tick(1);
    chk("R9 clear overrides clock edge", mc_fb, 1'b0);
    blk_init = 2'b00;
    tick(1);
    chk("R9 cleared value kept", mc_fb, 1'b0);
  endtask

  task automatic t_init_async();
    cfg_async = 1'b1;
    cfg_pt_fall = 1'b0;
    pt_clk = 1'b0;
    cfg_pt_to_rst = 1'b0;
    tick(1);
    pt_init = 1'b1;
    #1 chk("R8 pt_init sets", mc_fb, 1'b1);
    tick(1);
    pt_init = 1'b0;
    cfg_pt_to_rst = 1'b1;
    tick(1);
    chk("R8 set retained", mc_fb, 1'b1);
    pt_init = 1'b1;
    #1 chk("R8 pt_init clears", mc_fb, 1'b0);
    tick(1);
    pt_init = 1'b0;
    tick(1);
    blk_init = 2'b01;
    #1 chk("R8 blk_init ignored in async", mc_fb, 1'b0);
    tick(1);
    blk_init = 2'b00;
    tick(1);
    chk("R8 value after blk_init", mc_fb, 1'b0);
    cfg_async = 1'b0;
    tick(1);
  endtask

  task automatic t_toggle();
    cfg_kind = 2'd2;
    cfg_clk_sel = 2'd1;
    cfg_tff = 1'b1;
    tick(1);
    set_val(1'b0);
    sum_in = 1'b1;
    pulse_blk(1);
    chk("R10 toggle to one", mc_fb, 1'b1);
    pulse_blk(1);
    chk("R10 toggle to zero", mc_fb, 1'b0);
    pulse_blk(1);
    chk("R10 toggle to one again", mc_fb, 1'b1);
    sum_in = 1'b0;
    pulse_blk(1);
    chk("R10 zero input keeps value", mc_fb, 1'b1);
    cfg_tff = 1'b0;
    tick(1);
  endtask

  task automatic t_route();
    cfg_route = 1'b0;
    #1 chk("R11 routed output off", mc_out, 1'b0);
    chk("R11 feedback still valid", mc_fb, 1'b1);
    tick(1);
    cfg_route = 1'b1;
    #1 chk("R11 routed output on", mc_out, 1'b1);
    tick(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sum_in = 1'b0;
    blk_clk = 4'b0000;
    pt_clk = 1'b0;
    blk_init = 2'b00;
    pt_init = 1'b0;
    cfg_kind = 2'd2;
    cfg_async = 1'b0;
    cfg_clk_sel = 2'd0;
    cfg_pt_fall = 1'b0;
    cfg_swap = 1'b0;
    cfg_pt_to_rst = 1'b1;
    cfg_tff = 1'b0;
    cfg_route = 1'b1;
    t_reset();
    t_comb();
    t_reg_sync();
    t_latch();
    t_async_clk();
    t_init_sync();
    t_init_async();
    t_toggle();
    t_route();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule